// File: doc/BRIEF.md
# Keyboard and Display Register Port

This block is a slave on a 16-bit processor memory bus. It holds four registers at fixed word-aligned addresses: a keyboard status word, a keyboard data word, a display status word and a display data word. A single-cycle strobe from the keyboard side delivers an 8-bit character code. A display-side pulse pair hands a character out and reports when the display has finished with it. Software polls the ready bits, or enables per-device interrupts, to pace transfers in both directions.

Each status word has a read-only ready flag in bit 15 and a software-writable interrupt-enable flag in bit 14. While a character waits to be read, the keyboard side is locked and further keystrokes are lost. While the display is busy, further data writes are lost. A hit output tells the processor's read multiplexer to take this block's data instead of memory data.

Top module: `kbd_disp_regs`

## Requirements
- R1: `bus_hit` is 1 in the same cycle as a read (`bus_rd`=1) of 0xFE00, 0xFE02, 0xFE04 or 0xFE06; for any other address, or with no read, `bus_hit` is 0 and `bus_rdata` is 0.
- R2: A `key_strobe` while keyboard ready is 0 stores `key_code`; from the next cycle a read of 0xFE02 returns {8'h00, code} and keyboard status bit 15 reads 1.
- R3: While keyboard ready is 1, strobes are dropped and the stored code is unchanged, including a strobe in the same cycle as the read of 0xFE02.
- R4: A read of 0xFE02 while keyboard ready is 1 clears keyboard status bit 15 from the next cycle, after which the next strobe is accepted.
- R5: After reset, keyboard status reads 0x0000 and display status reads 0x8000; `disp_valid` is 0.
- R6: A write to 0xFE06 while display ready (display status bit 15) is 1 clears display ready, and in the next cycle only `disp_valid` is 1 with `disp_char` equal to write data bits [7:0].
- R7: A write to 0xFE06 while display ready is 0 is dropped: no `disp_valid` pulse and `disp_char` is unchanged.
- R8: A `disp_done` pulse while display ready is 0 sets display ready to 1 from the next cycle; `disp_done` while ready is 1 has no effect.
- R9: A write to 0xFE00 or 0xFE04 sets only bit 14 (interrupt enable) of that status word from write data bit 14; ready bits are unchanged and all other status bits read 0.
- R10: `kbd_irq` is 1 exactly when keyboard ready and keyboard enable are both 1; `disp_irq` likewise for the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not hit |
| bus_hit | output | 1 | Read selects this block instead of memory |
| key_strobe | input | 1 | One-cycle character arrival |
| key_code | input | 8 | Arriving character code |
| disp_valid | output | 1 | One-cycle character hand-off to the display |
| disp_char | output | 8 | Character for the display |
| disp_done | input | 1 | One-cycle display completion |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
Keystrokes are sent both into an unlocked port and into a locked one, which separates a correct lockout from one that overwrites the pending code; a strobe coinciding with the clearing read shows whether the lock holds in that exact cycle. Display writes are made while ready, while busy, and in the same cycle as a completion pulse, which tells apart correct dropping from late or early acceptance. Status writes with all ones and all zeros show that only the enable bit moves and the ready flags survive. Every cycle is also compared against a behavioural model of the same rules.

// File: rtl/kd_pkg.sv
package kd_pkg;

    localparam int unsigned BUS_W   = 16;
    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned RDY_BIT = BUS_W - 1;
    localparam int unsigned IE_BIT  = BUS_W - 2;
    localparam int unsigned N_SLOTS = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } sel_e;

    typedef struct packed {
        logic ready;
        logic ie;
    } stat_t;

    function automatic logic [BUS_W-1:0] pack_status(stat_t s);
        logic [BUS_W-1:0] r;
        r          = '0;
        r[RDY_BIT] = s.ready;
        r[IE_BIT]  = s.ie;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] pack_char(logic [CHAR_W-1:0] c);
        return {{(BUS_W-CHAR_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/kd_decode.sv
module kd_decode
    import kd_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00,
    parameter int unsigned      STRIDE    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    logic [N_SLOTS-1:0] match;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE_ADDR + ADDR_W'(i * STRIDE);
        assign match[i] = (addr == SLOT_ADDR);
    end

    always_comb begin
        unique case (1'b1)
            match[0]: sel = SEL_KSTAT;
            match[1]: sel = SEL_KDATA;
            match[2]: sel = SEL_DSTAT;
            match[3]: sel = SEL_DDATA;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/kd_kbd_chan.sv
module kd_kbd_chan
    import kd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] code,
    input  logic              data_rd,
    input  logic              ie_wr,
    input  logic              ie_val,
    output stat_t             st,
    output logic [CHAR_W-1:0] ch
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{ready: 1'b0, ie: 1'b0};
            ch <= '0;
        end else begin
            if (ie_wr) st.ie <= ie_val;
            if (st.ready) begin
                if (data_rd) st.ready <= 1'b0;
            end else if (strobe) begin
                st.ready <= 1'b1;
                ch       <= code;
            end
        end
    end
endmodule

// File: rtl/kd_disp_chan.sv
module kd_disp_chan
    import kd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    input  logic              ie_wr,
    input  logic              ie_val,
    output stat_t             st,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{ready: 1'b1, ie: 1'b0};
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (ie_wr) st.ie <= ie_val;
            if (!st.ready) begin
                if (done) st.ready <= 1'b1;
            end else if (data_wr) begin
                st.ready  <= 1'b0;
                out_valid <= 1'b1;
                out_char  <= wchar;
            end
        end
    end
endmodule

// File: rtl/kbd_disp_regs.sv
module kbd_disp_regs
    import kd_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 16'hFE00,
    parameter int unsigned      STRIDE    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_hit,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_code,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_done,
    output logic              kbd_irq,
    output logic              disp_irq
);
    sel_e              sel;
    stat_t             kbd_st;
    stat_t             disp_st;
    logic [CHAR_W-1:0] kbd_ch;

    kd_decode #(
        .ADDR_W   (BUS_W),
        .BASE_ADDR(BASE_ADDR),
        .STRIDE   (STRIDE)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    kd_kbd_chan u_kbd (
        .clk    (clk),
        .rst    (rst),
        .strobe (key_strobe),
        .code   (key_code),
        .data_rd(bus_rd && sel == SEL_KDATA),
        .ie_wr  (bus_wr && sel == SEL_KSTAT),
        .ie_val (bus_wdata[IE_BIT]),
        .st     (kbd_st),
        .ch     (kbd_ch)
    );

    kd_disp_chan u_disp (
        .clk      (clk),
        .rst      (rst),
        .data_wr  (bus_wr && sel == SEL_DDATA),
        .wchar    (bus_wdata[CHAR_W-1:0]),
        .done     (disp_done),
        .ie_wr    (bus_wr && sel == SEL_DSTAT),
        .ie_val   (bus_wdata[IE_BIT]),
        .st       (disp_st),
        .out_valid(disp_valid),
        .out_char (disp_char)
    );

    assign bus_hit = bus_rd && (sel != SEL_NONE);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_KSTAT: bus_rdata = pack_status(kbd_st);
                SEL_KDATA: bus_rdata = pack_char(kbd_ch);
                SEL_DSTAT: bus_rdata = pack_status(disp_st);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign kbd_irq  = kbd_st.ready && kbd_st.ie;
    assign disp_irq = disp_st.ready && disp_st.ie;
endmodule

// File: rtl/kbd_disp_regs_checker.sv
module kbd_disp_regs_checker
    import kd_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 16'hFE00,
    parameter int unsigned      STRIDE    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [BUS_W-1:0]  bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              key_strobe,
    input logic [CHAR_W-1:0] key_code,
    input logic              disp_done,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_char,
    input stat_t             kbd_st,
    input stat_t             disp_st,
    input logic [CHAR_W-1:0] kbd_ch
);
    localparam logic [BUS_W-1:0] KDATA_A = BASE_ADDR + BUS_W'(STRIDE);
    localparam logic [BUS_W-1:0] DDATA_A = BASE_ADDR + BUS_W'(3 * STRIDE);

    logic kd_rd, dd_wr;
    assign kd_rd = bus_rd && bus_addr == KDATA_A;
    assign dd_wr = bus_wr && bus_addr == DDATA_A;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (disp_st.ready && !kbd_st.ready && !disp_valid)); // R5

    AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && !kbd_st.ready) |=> (kbd_st.ready && kbd_ch == $past(key_code))); // R2

    AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (kbd_st.ready && !kd_rd) |=> (kbd_st.ready && $stable(kbd_ch))); // R3

    AST_KEY_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (kbd_st.ready && kd_rd) |=> (!kbd_st.ready && $stable(kbd_ch))); // R4

    AST_DISP_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (disp_st.ready && dd_wr) |=> (!disp_st.ready && disp_valid
                                      && disp_char == $past(bus_wdata[CHAR_W-1:0]))); // R6

    AST_DISP_DROP: assert property (@(posedge clk) disable iff (rst)
        (!disp_st.ready && dd_wr) |=> (!disp_valid && $stable(disp_char))); // R7

    AST_DISP_DONE: assert property (@(posedge clk) disable iff (rst)
        (!disp_st.ready && disp_done) |=> disp_st.ready); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !disp_valid); // R6
endmodule

bind kbd_disp_regs kbd_disp_regs_checker #(
    .BASE_ADDR(BASE_ADDR),
    .STRIDE   (STRIDE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .key_strobe(key_strobe),
    .key_code  (key_code),
    .disp_done (disp_done),
    .disp_valid(disp_valid),
    .disp_char (disp_char),
    .kbd_st    (kbd_st),
    .disp_st   (disp_st),
    .kbd_ch    (kbd_ch)
);

// File: tb/kbd_disp_regs_tb.sv
module kbd_disp_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_code = '0;
    logic        disp_valid;
    logic [7:0]  disp_char;
    logic        disp_done = 1'b0;
    logic        kbd_irq;
    logic        disp_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    kbd_disp_regs u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_hit   (bus_hit),
        .key_strobe(key_strobe),
        .key_code  (key_code),
        .disp_valid(disp_valid),
        .disp_char (disp_char),
        .disp_done (disp_done),
        .kbd_irq   (kbd_irq),
        .disp_irq  (disp_irq)
    );

    // Behavioural reference state
    bit       m_kr, m_kie, m_dr, m_die, m_dv;
    bit [7:0] m_kc, m_dc;

    always @(posedge clk) begin
        if (rst) begin
            m_kr <= 0; m_kie <= 0; m_kc <= 0;
            m_dr <= 1; m_die <= 0; m_dv <= 0; m_dc <= 0;
        end else begin
            m_dv <= 0;
            if (bus_wr && bus_addr == 16'hFE00) m_kie <= bus_wdata[14];
            if (bus_wr && bus_addr == 16'hFE04) m_die <= bus_wdata[14];
            if (m_kr) begin
                if (bus_rd && bus_addr == 16'hFE02) m_kr <= 0;
            end else if (key_strobe) begin
                m_kr <= 1; m_kc <= key_code;
            end
            if (!m_dr) begin
                if (disp_done) m_dr <= 1;
            end else if (bus_wr && bus_addr == 16'hFE06) begin
                m_dr <= 0; m_dv <= 1; m_dc <= bus_wdata[7:0];
            end
        end
    end

    function automatic logic [15:0] exp_rdata();
        if (!bus_rd) return 16'h0;
        case (bus_addr)
            16'hFE00: return {m_kr, m_kie, 14'h0};
            16'hFE02: return {8'h00, m_kc};
            16'hFE04: return {m_dr, m_die, 14'h0};
            default:  return 16'h0;
        endcase
    endfunction

    function automatic logic exp_hit();
        return bus_rd && (bus_addr == 16'hFE00 || bus_addr == 16'hFE02 ||
                          bus_addr == 16'hFE04 || bus_addr == 16'hFE06);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 hit", {15'h0, bus_hit}, {15'h0, exp_hit()});
            chk("R9 rdata", bus_rdata, exp_rdata());
            chk("R10 kbd_irq", {15'h0, kbd_irq}, {15'h0, m_kr && m_kie});
            chk("R10 disp_irq", {15'h0, disp_irq}, {15'h0, m_dr && m_die});
            chk("R6 valid", {15'h0, disp_valid}, {15'h0, m_dv});
            chk("R7 char", {8'h0, disp_char}, {8'h0, m_dc});
        end
    end

    task automatic cyc(bit rd, bit wr, logic [15:0] a, logic [15:0] d,
                       bit ks, logic [7:0] kc, bit dn);
        @(posedge clk); #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        key_strobe = ks; key_code = kc; disp_done = dn;
    endtask

    task automatic idle();           cyc(0, 0, 16'h0, 16'h0, 0, 8'h0, 0); endtask
    task automatic rd(logic [15:0] a); cyc(1, 0, a, 16'h0, 0, 8'h0, 0); endtask
    task automatic wr(logic [15:0] a, logic [15:0] d); cyc(0, 1, a, d, 0, 8'h0, 0); endtask
    task automatic key(logic [7:0] c); cyc(0, 0, 16'h0, 16'h0, 1, c, 0); endtask
    task automatic done_p();         cyc(0, 0, 16'h0, 16'h0, 0, 8'h0, 1); endtask

    task automatic see(string req, logic [15:0] exp_rd);
        @(negedge clk);
        chk(req, bus_rdata, exp_rd);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R5 reset state
        rd(16'hFE00); see("R5 kbd status", 16'h0000);
        chk("R5 valid", {15'h0, disp_valid}, 16'h0);
        rd(16'hFE04); see("R5 disp status", 16'h8000);

        // R1 misses
        rd(16'h3000); see("R1 miss rdata", 16'h0000);
        chk("R1 miss hit", {15'h0, bus_hit}, 16'h0);
        rd(16'hFE01); see("R1 odd addr", 16'h0000);
        chk("R1 odd hit", {15'h0, bus_hit}, 16'h0);
        rd(16'hFE06); see("R1 ddata read", 16'h0000);
        chk("R1 ddata hit", {15'h0, bus_hit}, 16'h1);

        // R2 capture, R3 lockout, R4 unlock
        key(8'h41);
        rd(16'hFE00); see("R2 ready set", 16'h8000);
        key(8'h42);
        rd(16'hFE02); see("R3 locked keeps code", 16'h0041);
        rd(16'hFE00); see("R4 ready cleared", 16'h0000);
        key(8'h43);
        rd(16'hFE02); see("R4 next accepted", 16'h0043);
        key(8'h45);
        cyc(1, 0, 16'hFE02, 16'h0, 1, 8'h46, 0); see("R3 read with strobe", 16'h0045);
        rd(16'hFE00); see("R3 same-cycle strobe dropped", 16'h0000);

        // R9 / R10 keyboard enable
        wr(16'hFE00, 16'hFFFF);
        rd(16'hFE00); see("R9 only ie set", 16'h4000);
        chk("R10 kbd irq low", {15'h0, kbd_irq}, 16'h0);
        key(8'h55);
        rd(16'hFE00); see("R9 ready and ie", 16'hC000);
        chk("R10 kbd irq high", {15'h0, kbd_irq}, 16'h1);
        wr(16'hFE00, 16'h0000);
        rd(16'hFE00); see("R9 ready kept", 16'h8000);
        chk("R10 kbd irq off", {15'h0, kbd_irq}, 16'h0);
        rd(16'hFE02); see("R2 code", 16'h0055);

        // R6 display accept
        wr(16'hFE06, 16'h1234);
        idle(); @(negedge clk);
        chk("R6 valid pulse", {15'h0, disp_valid}, 16'h1);
        chk("R6 char", {8'h0, disp_char}, 16'h0034);
        rd(16'hFE04); see("R6 busy status", 16'h0000);
        chk("R6 single pulse", {15'h0, disp_valid}, 16'h0);

        // R7 drop while busy
        wr(16'hFE06, 16'h0077);
        idle(); @(negedge clk);
        chk("R7 no pulse", {15'h0, disp_valid}, 16'h0);
        chk("R7 char kept", {8'h0, disp_char}, 16'h0034);

        // R8 done
        done_p();
        rd(16'hFE04); see("R8 ready after done", 16'h8000);
        done_p();
        rd(16'hFE04); see("R8 done while ready", 16'h8000);

        // R10 display enable
        wr(16'hFE04, 16'h4000);
        rd(16'hFE04); see("R9 disp ie", 16'hC000);
        chk("R10 disp irq high", {15'h0, disp_irq}, 16'h1);
        wr(16'hFE06, 16'h0099);
        idle(); @(negedge clk);
        chk("R10 disp irq low", {15'h0, disp_irq}, 16'h0);
        chk("R6 second char", {8'h0, disp_char}, 16'h0099);

        // R7 write in same cycle as done while busy
        cyc(0, 1, 16'hFE06, 16'h0011, 0, 8'h0, 1);
        idle(); @(negedge clk);
        chk("R7 write with done dropped", {15'h0, disp_valid}, 16'h0);
        chk("R7 char after done", {8'h0, disp_char}, 16'h0099);
        rd(16'hFE04); see("R8 ready with ie", 16'hC000);

        idle(); idle();
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule